// File: doc/BRIEF.md
# DRAM Bank Command Sequencer

This block drives a single DRAM bank. It takes one abstract access request at a time (row, column, read or write) and turns it into the bank commands the access needs: row activate, column read, column write, precharge and refresh. It tracks whether a row is open and which row that is. Four down-counters keep the minimum spacing between commands.

A run-time policy input selects the row-buffer policy. In open-page mode a row stays open after an access, so a later access to the same row costs only one column command. In close-page mode the bank is precharged on the cycle right after every column command.

A refresh interval timer runs in the background. Each time it expires, the block closes any open row and refreshes one row. A refresh row pointer advances by one with each refresh, so the whole bank is covered over many intervals.

Top module: `dram_bank_seq`

## Requirements
- R1: After reset, no row is open, `cmd` is NOP, `req_ready` is 1 and `refresh_busy` is 0.
- R2: A request to a bank with no open row first issues ACT with the request row on `cmd_addr`. ACT is issued only once T_RP cycles have passed since the last PRE and T_RC cycles have passed since the last ACT or REF.
- R3: When the held request's row is already open, the block issues RD or WR with the column on `cmd_addr`. This needs at least T_RCD cycles since the ACT. `done` is 1 in that cycle, and `row_hit` is 1 with it only if no ACT was issued for that request.
- R4: With `policy_close` at 1 during a column command, the next cycle issues PRE, so the next access starts with ACT.
- R5: A request to a row other than the open one first issues PRE, with the open row on `cmd_addr`, and then ACT.
- R6: Any two commands from the set {ACT, REF} are at least T_RC cycles apart.
- R7: RD follows the last WR by at least T_WTR cycles.
- R8: A refresh request is raised every T_REFI cycles after reset. The block precharges any open row, then issues REF with the refresh row pointer on `cmd_addr`. The pointer starts at 0 and advances by 1, modulo 2^ROW_W, after each REF.
- R9: While a refresh is pending, `refresh_busy` is 1 and no ACT, RD or WR is issued. A pending precharge from close-page mode still goes first.
- R10: `req_ready` is 1 exactly when no request is held. A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge.
- R11: `cmd` encoding: NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5. `cmd_addr` is 0 during NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| policy_close | input | 1 | 1 = close-page, 0 = open-page |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_write | input | 1 | 1 = write, 0 = read |
| cmd | output | 3 | Bank command this cycle |
| cmd_addr | output | ADDR_W | Row or column address of the command |
| done | output | 1 | Column command for the held request issued |
| row_hit | output | 1 | Completed request found its row already open |
| refresh_busy | output | 1 | Refresh pending |

## Verification
The assertions assume the request fields stay stable while `req_valid` is high and not yet taken. They also assume `policy_close` is read only in the cycle of a column command. The stimulus meets the first assumption by holding the row, column and direction from the cycle it raises `req_valid` until it sees `req_ready`. It changes the policy only between request batches. The request rows come from a small set, so hits, conflicts, write-to-read turns and refreshes that land during an access all occur many times.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;
endpackage

// File: rtl/seq_timer.sv
// Minimum-spacing down-counter: ok is high once T cycles have passed since start.
module seq_timer #(
  parameter int unsigned T = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ok
);
  localparam int unsigned W = (T < 2) ? 1 : $clog2(T + 1);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (start)             cnt_n = W'(T - 1);
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign ok = (cnt_q == '0);
endmodule

// File: rtl/refresh_ctl.sv
// Interval timer and row pointer for distributed refresh.
module refresh_ctl #(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned T_REFI = 780
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_issue,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);
  localparam int unsigned IW = $clog2(T_REFI + 1);

  logic [IW-1:0]    ivl_q, ivl_n;
  logic             pend_q, pend_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic             fire;

  assign fire = (ivl_q == '0);

  always_comb begin
    ivl_n  = fire ? IW'(T_REFI - 1) : ivl_q - 1'b1;
    pend_n = (pend_q & ~ref_issue) | fire;
    row_n  = ref_issue ? row_q + 1'b1 : row_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivl_q  <= IW'(T_REFI - 1);
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      ivl_q  <= ivl_n;
      pend_q <= pend_n;
      if (ref_issue) row_q <= row_n;
    end
  end

  assign ref_pending = pend_q;
  assign ref_row     = row_q;

  p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_issue |=> (ref_row == $past(ref_row) + 1'b1));
endmodule

// File: rtl/bank_fsm.sv
// Row-buffer state, held request and command selection for one bank.
module bank_fsm
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              policy_close,
  input  logic              req_valid,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              req_ready,
  input  logic              rc_ok,
  input  logic              rcd_ok,
  input  logic              rp_ok,
  input  logic              wtr_ok,
  input  logic              ref_pending,
  input  logic [ROW_W-1:0]  ref_row,
  output cmd_e              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              hit_o,
  output logic              start_act,
  output logic              start_pre,
  output logic              start_wr,
  output logic              ref_issue
);
  logic             open_q, open_n;
  logic [ROW_W-1:0] orow_q, orow_n;
  logic             pclose_q, pclose_n;
  logic             hold_q, hold_n;
  logic [ROW_W-1:0] hrow_q;
  logic [COL_W-1:0] hcol_q;
  logic             hwr_q;
  logic             acted_q, acted_n;
  logic             accept, is_col;

  assign req_ready = ~hold_q;
  assign accept    = req_valid & ~hold_q;

  // Command selection, highest priority first.
  always_comb begin
    cmd_o  = CMD_NOP;
    addr_o = '0;
    done_o = 1'b0;
    hit_o  = 1'b0;
    if (pclose_q) begin
      cmd_o  = CMD_PRE;
      addr_o = ADDR_W'(orow_q);
    end else if (ref_pending) begin
      if (open_q) begin
        cmd_o  = CMD_PRE;
        addr_o = ADDR_W'(orow_q);
      end else if (rp_ok && rc_ok) begin
        cmd_o  = CMD_REF;
        addr_o = ADDR_W'(ref_row);
      end
    end else if (hold_q) begin
      if (open_q) begin
        if (orow_q == hrow_q) begin
          if (rcd_ok && (hwr_q || wtr_ok)) begin
            cmd_o  = hwr_q ? CMD_WR : CMD_RD;
            addr_o = ADDR_W'(hcol_q);
            done_o = 1'b1;
            hit_o  = ~acted_q;
          end
        end else begin
          cmd_o  = CMD_PRE;
          addr_o = ADDR_W'(orow_q);
        end
      end else if (rp_ok && rc_ok) begin
        cmd_o  = CMD_ACT;
        addr_o = ADDR_W'(hrow_q);
      end
    end
  end

  assign is_col    = (cmd_o == CMD_RD) || (cmd_o == CMD_WR);
  assign start_act = (cmd_o == CMD_ACT);
  assign start_pre = (cmd_o == CMD_PRE);
  assign start_wr  = (cmd_o == CMD_WR);
  assign ref_issue = (cmd_o == CMD_REF);

  always_comb begin
    open_n   = open_q;
    orow_n   = orow_q;
    pclose_n = pclose_q;
    hold_n   = hold_q;
    acted_n  = acted_q;
    if (start_act) begin
      open_n  = 1'b1;
      orow_n  = hrow_q;
      acted_n = 1'b1;
    end
    if (start_pre) begin
      open_n   = 1'b0;
      pclose_n = 1'b0;
    end
    if (is_col) begin
      hold_n   = 1'b0;
      pclose_n = policy_close;
    end
    if (accept) begin
      hold_n  = 1'b1;
      acted_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      orow_q   <= '0;
      pclose_q <= 1'b0;
      hold_q   <= 1'b0;
      acted_q  <= 1'b0;
      hrow_q   <= '0;
      hcol_q   <= '0;
      hwr_q    <= 1'b0;
    end else begin
      open_q   <= open_n;
      pclose_q <= pclose_n;
      hold_q   <= hold_n;
      acted_q  <= acted_n;
      if (start_act) orow_q <= orow_n;
      if (accept) begin
        hrow_q <= req_row;
        hcol_q <= req_col;
        hwr_q  <= req_write;
      end
    end
  end

  p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_ACT) |-> !open_q);
  p_col_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> (open_q && orow_q == hrow_q));
  p_close_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col && policy_close) |=> (cmd_o == CMD_PRE));
  p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pending |-> !(is_col || cmd_o == CMD_ACT));
endmodule

// File: rtl/dram_bank_seq.sv
module dram_bank_seq
  import dram_seq_pkg::*;
#(
  parameter int unsigned ROW_W  = 8,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int unsigned T_RC   = 8,
  parameter int unsigned T_RCD  = 3,
  parameter int unsigned T_RP   = 3,
  parameter int unsigned T_WTR  = 4,
  parameter int unsigned T_REFI = 780
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              policy_close,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic [2:0]        cmd,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              done,
  output logic              row_hit,
  output logic              refresh_busy
);
  localparam int unsigned NT = 4;
  localparam int unsigned TV [NT] = '{T_RC, T_RCD, T_RP, T_WTR};

  cmd_e             cmd_w;
  logic [NT-1:0]    tstart, tok;
  logic             start_act, start_pre, start_wr, ref_issue;
  logic             ref_pending;
  logic [ROW_W-1:0] ref_row;

  // Timer order: 0 = tRC, 1 = tRCD, 2 = tRP, 3 = tWTR
  assign tstart = {start_wr, start_pre, start_act, start_act | ref_issue};

  for (genvar gi = 0; gi < NT; gi++) begin : g_tmr
    seq_timer #(.T(TV[gi])) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tstart[gi]), .ok(tok[gi])
    );
  end

  refresh_ctl #(.ROW_W(ROW_W), .T_REFI(T_REFI)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_issue(ref_issue),
    .ref_pending(ref_pending), .ref_row(ref_row)
  );

  bank_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .policy_close(policy_close),
    .req_valid(req_valid), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .req_ready(req_ready),
    .rc_ok(tok[0]), .rcd_ok(tok[1]), .rp_ok(tok[2]), .wtr_ok(tok[3]),
    .ref_pending(ref_pending), .ref_row(ref_row),
    .cmd_o(cmd_w), .addr_o(cmd_addr), .done_o(done), .hit_o(row_hit),
    .start_act(start_act), .start_pre(start_pre), .start_wr(start_wr),
    .ref_issue(ref_issue)
  );

  assign cmd          = cmd_w;
  assign refresh_busy = ref_pending;

  // Independent up-counters measuring spacing at the command port.
  localparam int unsigned SW = $clog2(T_RC + T_WTR + 1);
  logic [SW-1:0] since_act_q, since_wr_q;
  logic          is_act_ref;
  assign is_act_ref = (cmd == 3'd1) || (cmd == 3'd5);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act_q <= SW'(T_RC);
      since_wr_q  <= SW'(T_WTR);
    end else begin
      if (is_act_ref)                    since_act_q <= SW'(1);
      else if (since_act_q < SW'(T_RC))  since_act_q <= since_act_q + 1'b1;
      if (cmd == 3'd3)                   since_wr_q  <= SW'(1);
      else if (since_wr_q < SW'(T_WTR))  since_wr_q  <= since_wr_q + 1'b1;
    end
  end

  p_act_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_act_ref |-> (since_act_q >= SW'(T_RC)));
  p_wr_to_rd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'd2) |-> (since_wr_q >= SW'(T_WTR)));
  p_ready_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !done) |=> !req_ready);
endmodule

// File: tb/tb_dram_bank_seq.sv
module tb_dram_bank_seq;
  localparam int ROW_W = 4, COL_W = 5, ADDR_W = 5;
  localparam int T_RC = 6, T_RCD = 2, T_RP = 3, T_WTR = 4, T_REFI = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic policy_close = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, done, row_hit, refresh_busy;
  logic [2:0] cmd;
  logic [ADDR_W-1:0] cmd_addr;

  always #10 clk = ~clk;  // 50 MHz

  dram_bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RC(T_RC), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_WTR(T_WTR), .T_REFI(T_REFI)) dut (
    .clk(clk), .rst_n(rst_n), .policy_close(policy_close), .req_valid(req_valid),
    .req_ready(req_ready), .req_row(req_row), .req_col(req_col),
    .req_write(req_write), .cmd(cmd), .cmd_addr(cmd_addr), .done(done),
    .row_hit(row_hit), .refresh_busy(refresh_busy));

  int vectors = 0, errors = 0, cycles = 0;
  bit finished = 0;

  // Reference model state (R11 codes: NOP 0, ACT 1, RD 2, WR 3, PRE 4, REF 5)
  int m_open, m_orow, m_hold, m_hrow, m_hcol, m_hwr, m_acted, m_pclose;
  int m_refp, m_refrow, t_act, t_pre, t_wr, tick;
  int e_cmd, e_addr, e_done, e_hit;

  // Observation trackers for explicit checks
  int o_act = -100, o_wr = -100, o_refs = 0, o_prev_close_col = 0;

  task automatic model_reset();
    m_open = 0; m_orow = 0; m_hold = 0; m_hrow = 0; m_hcol = 0; m_hwr = 0;
    m_acted = 0; m_pclose = 0; m_refp = 0; m_refrow = 0;
    t_act = -100; t_pre = -100; t_wr = -100; tick = 0;
  endtask

  task automatic model_decide();
    bit rp, rc, rcd, wtr;
    rp = (tick - t_pre) >= T_RP; rc = (tick - t_act) >= T_RC;
    rcd = (tick - t_act) >= T_RCD; wtr = (tick - t_wr) >= T_WTR;
    e_cmd = 0; e_addr = 0; e_done = 0; e_hit = 0;
    if (m_pclose) begin e_cmd = 4; e_addr = m_orow; end
    else if (m_refp) begin
      if (m_open) begin e_cmd = 4; e_addr = m_orow; end
      else if (rp && rc) begin e_cmd = 5; e_addr = m_refrow; end
    end else if (m_hold) begin
      if (m_open && m_orow == m_hrow) begin
        if (rcd && (m_hwr || wtr)) begin
          e_cmd = m_hwr ? 3 : 2; e_addr = m_hcol; e_done = 1; e_hit = !m_acted;
        end
      end else if (m_open) begin e_cmd = 4; e_addr = m_orow; end
      else if (rp && rc) begin e_cmd = 1; e_addr = m_hrow; end
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic string tag_of(input int c);
    case (c)
      1: return "R2"; 2, 3: return "R3"; 4: return "R5"; 5: return "R8";
      default: return "R11";
    endcase
  endfunction

  // Compare against the model away from the clock edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      #1;
      model_decide();
      check(tag_of(e_cmd), int'(cmd), e_cmd);
      check(tag_of(e_cmd), int'(cmd_addr), e_addr);
      check("R3", int'(done), e_done);
      check("R3", int'(row_hit), e_hit);
      check("R10", int'(req_ready), !m_hold);
      check("R9", int'(refresh_busy), m_refp);
      // R4: column under close policy is followed by PRE
      if (o_prev_close_col) check("R4", int'(cmd), 4);
      o_prev_close_col = (cmd == 3'd2 || cmd == 3'd3) && policy_close;
      // R6: ACT/REF spacing observed at the port
      if (cmd == 3'd1 || cmd == 3'd5) begin
        check("R6", int'((tick - o_act) >= T_RC), 1);
        o_act = tick;
      end
      // R7: write-to-read turnaround observed at the port
      if (cmd == 3'd2) check("R7", int'((tick - o_wr) >= T_WTR), 1);
      if (cmd == 3'd3) o_wr = tick;
      // R8: refresh row pointer walks 0,1,2,... modulo 2^ROW_W
      if (cmd == 3'd5) begin
        check("R8", int'(cmd_addr), o_refs % (1 << ROW_W));
        o_refs++;
      end
    end
  end

  // Advance the model at each edge using the decision made for this cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int cur;
      bit acc;
      cur = tick;
      acc = req_valid && !m_hold;
      if (e_cmd == 1) begin m_open = 1; m_orow = m_hrow; m_acted = 1; t_act = cur; end
      if (e_cmd == 4) begin m_open = 0; m_pclose = 0; t_pre = cur; end
      if (e_cmd == 5) begin m_refp = 0; m_refrow = (m_refrow + 1) % (1 << ROW_W); t_act = cur; end
      if (e_cmd == 2 || e_cmd == 3) begin m_hold = 0; m_pclose = policy_close; end
      if (e_cmd == 3) t_wr = cur;
      if (acc) begin
        m_hold = 1; m_acted = 0; m_hrow = req_row; m_hcol = req_col; m_hwr = req_write;
      end
      tick = cur + 1;
      if (tick % T_REFI == 0) m_refp = 1;
      e_cmd = 0;
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++; vectors++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
      finish_run();
    end
  end

  task automatic send(input int r, input int c, input bit w);
    @(negedge clk);
    req_valid = 1'b1; req_row = ROW_W'(r); req_col = COL_W'(c); req_write = w;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    model_reset();
    e_cmd = 0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    check("R1", int'(cmd), 0);
    check("R1", int'(req_ready), 1);
    check("R1", int'(refresh_busy), 0);
    rst_n = 1'b1;
    // R2/R3: open page, activate then hits
    policy_close = 1'b0;
    send(2, 5, 0); send(2, 6, 0); send(2, 7, 1);
    // R7: read right after write to the same row
    send(2, 8, 0);
    // R5: row conflict
    send(3, 1, 0); send(1, 2, 1);
    idle(20);
    // R4/R6: close page, back-to-back activates
    policy_close = 1'b1;
    send(1, 3, 0); send(1, 4, 1); send(2, 9, 0); send(2, 10, 0);
    idle(5);
    policy_close = 1'b0;
    // R8/R9: leave a row open across refresh intervals
    send(4, 0, 0);
    idle(130);
    // Random traffic over a few rows, policy switched between batches
    for (int b = 0; b < 60; b++) begin
      policy_close = b[0] ^ b[2];
      for (int k = 0; k < 25; k++) begin
        send(int'($urandom_range(0, 3)), int'($urandom_range(0, 31)), 1'($urandom_range(0, 1)));
        idle(int'($urandom_range(0, 3)));
      end
    end
    // Long idle so the refresh pointer wraps past 2^ROW_W (R8)
    idle(T_REFI * 18);
    check("R8", int'(o_refs > (1 << ROW_W)), 1);
    finish_run();
  end
endmodule